// File: doc/BRIEF.md
# Register-File Stack and Return Sequencer

This block carries out the three stack instructions of a small 8-bit controller: push, pop and subroutine return. The stack lives in the same byte-wide register file as the working registers. The sequencer owns the stack pointer. It sends read and write requests to that register file, at most one per cycle. On a return it rebuilds a 16-bit program counter from two stacked bytes. Instruction fetch and the ALU sit outside; the block receives an opcode that has already been decoded, an operand byte and a start strobe. When it finishes it raises a one-cycle done pulse.

The register file has a synchronous read port. A read requested in cycle N returns its byte in cycle N+1. All outputs of the block are registered. A push decrements the pointer before it stores. A pop reads first and increments afterwards. A return consumes two stack bytes. None of the three changes the condition flags, so the block has no flag interface at all.

Top module: `rf_stack_seq`

## Requirements
- R1: While reset is high and after it is released, sp_o equals the parameter SP_RST (default 8'h00), and done_o, pc_load_o, rf_we_o and rf_re_o are all low.
- R2: Opcode 8'h70 (push, direct) reads the register addressed by operand_i, sets SP to SP-1 and writes that byte to the register at the new SP. done_o is high in the third cycle after the accepting clock edge.
- R3: Opcode 8'h50 (pop, direct) reads the register at SP, writes that byte to the register addressed by operand_i and sets SP to SP+1. done_o is high in the third cycle after the accepting edge.
- R4: Opcodes 8'h71 (push) and 8'h51 (pop) are indirect: operand_i names a register, and the byte held in that register is the source address (push) or destination address (pop). Reading that pointer delays done_o to the fifth cycle after the accepting edge.
- R5: Opcode 8'hAF (return) reads the high PC byte at SP and then the low byte at SP+1, on consecutive cycles. It presents pc_o = {high, low} with pc_load_o high for exactly the cycle in which done_o is high, which is the third cycle after the accepting edge. SP becomes SP+2.
- R6: The stack pointer wraps modulo 256. A push at SP 8'h00 stores at 8'hFF, and a return at SP 8'hFF reads 8'hFF then 8'h00 and leaves SP at 8'h01.
- R7: done_o is never high for two cycles in a row. sp_o changes only in a cycle where rf_we_o or pc_load_o is high. Every write is followed in the next cycle by done_o.
- R8: A start while an operation is in progress has no effect. A start with any other opcode value is ignored: no done_o, no write and no change of SP.
- R9: rf_we_o and rf_re_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an operation; sampled only while idle |
| opcode_i | input | 8 | Decoded instruction opcode |
| operand_i | input | W | Register address (direct) or pointer register address (indirect) |
| rf_rdata_i | input | W | Read data from the register file, one cycle after the request |
| rf_addr_o | output | W | Register-file address for the read or write request |
| rf_re_o | output | 1 | Read request |
| rf_we_o | output | 1 | Write request |
| rf_wdata_o | output | W | Write data |
| sp_o | output | W | Current stack pointer |
| pc_o | output | 2*W | Program counter rebuilt by a return |
| pc_load_o | output | 1 | pc_o is valid and should be loaded |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Counting from the clock edge that accepts start_i, each register in the path is counted. Direct push, direct pop and return finish three cycles later, and indirect push and pop finish five cycles later. The write lands on the same edge that raises done_o, and the return's PC and pointer update land with it. Each stimulus records the cycle number of its accepting edge in its scoreboard entry. The monitor samples on the falling edge and checks that done_o appears exactly that many cycles later. At that point it compares the pointer, the PC and the written register against the bench's own model. Any done_o with no pending entry counts as a miscompare, and this is how ignored starts are caught.

// File: rtl/rf_stack_pkg.sv
package rf_stack_pkg;
  localparam logic [7:0] OP_PUSH_DIR = 8'h70;
  localparam logic [7:0] OP_PUSH_IND = 8'h71;
  localparam logic [7:0] OP_POP_DIR  = 8'h50;
  localparam logic [7:0] OP_POP_IND  = 8'h51;
  localparam logic [7:0] OP_RETURN   = 8'hAF;

  typedef enum logic [1:0] {K_NONE, K_PUSH, K_POP, K_RET} op_kind_t;

  typedef enum logic [3:0] {
    S_IDLE, S_PTR_REQ, S_PTR_DAT, S_ACC_REQ, S_ACC_DAT,
    S_WRITE, S_RET_HI, S_RET_LO, S_RET_CAP
  } seq_state_t;
endpackage

// File: rtl/rf_stack_decode.sv
module rf_stack_decode
  import rf_stack_pkg::*;
(
  input  logic [7:0] opcode,
  output op_kind_t   kind,
  output logic       indirect,
  output logic       valid
);
  always_comb begin
    kind     = K_NONE;
    indirect = 1'b0;
    unique case (opcode)
      OP_PUSH_DIR: kind = K_PUSH;
      OP_PUSH_IND: begin kind = K_PUSH; indirect = 1'b1; end
      OP_POP_DIR:  kind = K_POP;
      OP_POP_IND:  begin kind = K_POP;  indirect = 1'b1; end
      OP_RETURN:   kind = K_RET;
      default:     kind = K_NONE;
    endcase
    valid = (kind != K_NONE);
  end
endmodule

// File: rtl/rf_stack_ptr.sv
module rf_stack_ptr #(
  parameter int W = 8,
  parameter logic [W-1:0] SP_RST = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dec1,
  input  logic         inc1,
  input  logic         inc2,
  output logic [W-1:0] sp
);
  always_ff @(posedge clk) begin
    if (rst)       sp <= SP_RST;
    else if (dec1) sp <= sp - W'(1);
    else if (inc1) sp <= sp + W'(1);
    else if (inc2) sp <= sp + W'(2);
  end
endmodule

// File: rtl/rf_stack_fsm.sv
module rf_stack_fsm
  import rf_stack_pkg::*;
#(
  parameter int W = 8,
  localparam int PCW = 2 * W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  op_kind_t       kind,
  input  logic           indirect,
  input  logic           valid,
  input  logic [W-1:0]   operand,
  input  logic [W-1:0]   rdata,
  input  logic [W-1:0]   sp,
  output logic           sp_dec1,
  output logic           sp_inc1,
  output logic           sp_inc2,
  output logic [W-1:0]   rf_addr,
  output logic           rf_re,
  output logic           rf_we,
  output logic [W-1:0]   rf_wdata,
  output logic [PCW-1:0] pc,
  output logic           pc_load,
  output logic           done
);
  seq_state_t   state;
  op_kind_t     kind_q;
  logic [W-1:0] tgt_q;
  logic [W-1:0] hi_q;

  assign sp_dec1 = (state == S_ACC_DAT) && (kind_q == K_PUSH);
  assign sp_inc1 = (state == S_ACC_DAT) && (kind_q == K_POP);
  assign sp_inc2 = (state == S_RET_CAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      kind_q   <= K_NONE;
      tgt_q    <= '0;
      hi_q     <= '0;
      rf_addr  <= '0;
      rf_re    <= 1'b0;
      rf_we    <= 1'b0;
      rf_wdata <= '0;
      pc       <= '0;
      pc_load  <= 1'b0;
      done     <= 1'b0;
    end else begin
      rf_re   <= 1'b0;
      rf_we   <= 1'b0;
      pc_load <= 1'b0;
      done    <= 1'b0;
      unique case (state)
        S_IDLE: if (start && valid) begin
          kind_q <= kind;
          tgt_q  <= operand;
          rf_re  <= 1'b1;
          if (kind == K_RET) begin
            rf_addr <= sp;
            state   <= S_RET_HI;
          end else if (indirect) begin
            rf_addr <= operand;
            state   <= S_PTR_REQ;
          end else begin
            rf_addr <= (kind == K_PUSH) ? operand : sp;
            state   <= S_ACC_REQ;
          end
        end
        S_PTR_REQ: state <= S_PTR_DAT;
        S_PTR_DAT: begin
          rf_re <= 1'b1;
          state <= S_ACC_REQ;
          if (kind_q == K_PUSH) begin
            rf_addr <= rdata;
          end else begin
            tgt_q   <= rdata;
            rf_addr <= sp;
          end
        end
        S_ACC_REQ: state <= S_ACC_DAT;
        S_ACC_DAT: begin
          rf_we    <= 1'b1;
          rf_wdata <= rdata;
          rf_addr  <= (kind_q == K_PUSH) ? sp - W'(1) : tgt_q;
          state    <= S_WRITE;
        end
        S_WRITE: begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        S_RET_HI: begin
          rf_addr <= sp + W'(1);
          rf_re   <= 1'b1;
          state   <= S_RET_LO;
        end
        S_RET_LO: begin
          hi_q  <= rdata;
          state <= S_RET_CAP;
        end
        S_RET_CAP: begin
          pc      <= {hi_q, rdata};
          pc_load <= 1'b1;
          done    <= 1'b1;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rf_stack_seq.sv
module rf_stack_seq
  import rf_stack_pkg::*;
#(
  parameter int W = 8,
  parameter logic [W-1:0] SP_RST = '0,
  localparam int PCW = 2 * W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic [7:0]     opcode_i,
  input  logic [W-1:0]   operand_i,
  input  logic [W-1:0]   rf_rdata_i,
  output logic [W-1:0]   rf_addr_o,
  output logic           rf_re_o,
  output logic           rf_we_o,
  output logic [W-1:0]   rf_wdata_o,
  output logic [W-1:0]   sp_o,
  output logic [PCW-1:0] pc_o,
  output logic           pc_load_o,
  output logic           done_o
);
  op_kind_t kind;
  logic     indirect, valid;
  logic     dec1, inc1, inc2;

  rf_stack_decode u_dec (
    .opcode(opcode_i), .kind(kind), .indirect(indirect), .valid(valid)
  );

  rf_stack_ptr #(.W(W), .SP_RST(SP_RST)) u_ptr (
    .clk(clk), .rst(rst), .dec1(dec1), .inc1(inc1), .inc2(inc2), .sp(sp_o)
  );

  rf_stack_fsm #(.W(W)) u_fsm (
    .clk(clk), .rst(rst), .start(start_i), .kind(kind), .indirect(indirect),
    .valid(valid), .operand(operand_i), .rdata(rf_rdata_i), .sp(sp_o),
    .sp_dec1(dec1), .sp_inc1(inc1), .sp_inc2(inc2),
    .rf_addr(rf_addr_o), .rf_re(rf_re_o), .rf_we(rf_we_o),
    .rf_wdata(rf_wdata_o), .pc(pc_o), .pc_load(pc_load_o), .done(done_o)
  );
endmodule

// File: rtl/rf_stack_chk.sv
module rf_stack_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         rf_re_o,
  input logic         rf_we_o,
  input logic [W-1:0] sp_o,
  input logic         pc_load_o,
  input logic         done_o
);
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  a_r7_write_then_done: assert property (@(posedge clk) disable iff (rst)
    rf_we_o |=> done_o);
  a_r7_sp_moves_with_access: assert property (@(posedge clk) disable iff (rst)
    !$stable(sp_o) |-> (rf_we_o || pc_load_o));
  a_r5_load_with_done: assert property (@(posedge clk) disable iff (rst)
    pc_load_o |-> done_o);
  a_r5_return_adds_two: assert property (@(posedge clk) disable iff (rst)
    pc_load_o |-> (sp_o == $past(sp_o) + W'(2)));
  a_r9_no_read_and_write: assert property (@(posedge clk) disable iff (rst)
    !(rf_we_o && rf_re_o));
endmodule

bind rf_stack_seq rf_stack_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .rf_re_o(rf_re_o), .rf_we_o(rf_we_o),
  .sp_o(sp_o), .pc_load_o(pc_load_o), .done_o(done_o)
);

// File: tb/rf_stack_seq_bench.sv
`timescale 1ns/1ps
module rf_stack_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [7:0]  opcode_i = '0;
  logic [7:0]  operand_i = '0;
  logic [7:0]  rf_rdata_i;
  logic [7:0]  rf_addr_o, rf_wdata_o, sp_o;
  logic        rf_re_o, rf_we_o, pc_load_o, done_o;
  logic [15:0] pc_o;

  always #2.5 clk = ~clk;

  rf_stack_seq u_rf_stack_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .opcode_i(opcode_i),
    .operand_i(operand_i), .rf_rdata_i(rf_rdata_i), .rf_addr_o(rf_addr_o),
    .rf_re_o(rf_re_o), .rf_we_o(rf_we_o), .rf_wdata_o(rf_wdata_o),
    .sp_o(sp_o), .pc_o(pc_o), .pc_load_o(pc_load_o), .done_o(done_o)
  );

  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];
  always @(posedge clk) begin
    if (rf_we_o) mem[rf_addr_o] <= rf_wdata_o;
    if (rf_re_o) rf_rdata_i <= mem[rf_addr_o];
  end

  typedef struct {
    int          lat;
    int          t0;
    logic [7:0]  sp;
    bit          is_ret;
    logic [15:0] pc;
    logic [7:0]  addr;
    logic [7:0]  val;
    string       req;
  } item_t;
  item_t q[$];

  int cyc = 0, nchk = 0, nfail = 0, nwe = 0;
  logic [7:0] ref_sp;
  logic       prev_done = 1'b0;
  logic [7:0] prev_sp = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (rf_we_o) nwe++;
      if (done_o && prev_done) check("R7", "done two cycles", 1, 0);
      if (sp_o != prev_sp && !(rf_we_o || pc_load_o))
        check("R7", "sp moved without access", {24'd0, sp_o}, {24'd0, prev_sp});
      if (pc_load_o && !done_o) check("R5", "pc_load without done", 1, 0);
      if (done_o) begin
        if (q.size() == 0) begin
          check("R8", "unexpected done", 1, 0);
        end else begin
          item_t it;
          it = q.pop_front();
          check(it.req, "done latency", cyc - it.t0, it.lat);
          check(it.req, "stack pointer", {24'd0, sp_o}, {24'd0, it.sp});
          if (it.is_ret) begin
            check(it.req, "pc value", {16'd0, pc_o}, {16'd0, it.pc});
            check(it.req, "pc_load", {31'd0, pc_load_o}, 1);
          end else begin
            check(it.req, "stored byte", {24'd0, mem[it.addr]}, {24'd0, it.val});
            check(it.req, "pc_load idle", {31'd0, pc_load_o}, 0);
          end
        end
      end
      prev_done = done_o;
      prev_sp   = sp_o;
    end
  end

  // driver: computes the expected outcome and queues it
  task automatic run_op(logic [7:0] op, logic [7:0] opd, string req, bit poke_busy);
    item_t it;
    logic [7:0] t, v;
    it.is_ret = 0; it.pc = '0; it.addr = '0; it.val = '0; it.req = req;
    case (op)
      8'h70: begin v = ref_mem[opd]; ref_sp = ref_sp - 8'd1; ref_mem[ref_sp] = v;
                   it.addr = ref_sp; it.val = v; it.lat = 3; end
      8'h71: begin v = ref_mem[ref_mem[opd]]; ref_sp = ref_sp - 8'd1; ref_mem[ref_sp] = v;
                   it.addr = ref_sp; it.val = v; it.lat = 5; end
      8'h50: begin v = ref_mem[ref_sp]; ref_mem[opd] = v; ref_sp = ref_sp + 8'd1;
                   it.addr = opd; it.val = v; it.lat = 3; end
      8'h51: begin t = ref_mem[opd]; v = ref_mem[ref_sp]; ref_mem[t] = v;
                   ref_sp = ref_sp + 8'd1; it.addr = t; it.val = v; it.lat = 5; end
      default: begin it.is_ret = 1; it.pc = {ref_mem[ref_sp], ref_mem[ref_sp + 8'd1]};
                   ref_sp = ref_sp + 8'd2; it.lat = 3; end
    endcase
    it.sp = ref_sp;
    @(negedge clk);
    start_i = 1'b1; opcode_i = op; operand_i = opd;
    @(negedge clk);
    it.t0 = cyc;
    q.push_back(it);
    if (poke_busy) begin
      opcode_i = 8'h70; operand_i = 8'h05;   // R8: start while busy
    end else begin
      start_i = 1'b0;
    end
    @(negedge clk);
    start_i = 1'b0;
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check("ALL", "watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
    mem[8'h30] = 8'h12; ref_mem[8'h30] = 8'h12;
    mem[8'h31] = 8'h22; ref_mem[8'h31] = 8'h22;
    ref_sp = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "sp in reset", {24'd0, sp_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "sp after reset", {24'd0, sp_o}, 0);
    check("R1", "outputs idle", {28'd0, done_o, pc_load_o, rf_we_o, rf_re_o}, 0);

    run_op(8'h70, 8'h10, "R6", 0);   // R2 push direct, SP 00 wraps to FF
    run_op(8'h70, 8'h11, "R2", 0);
    run_op(8'h50, 8'h20, "R3", 0);
    run_op(8'h71, 8'h30, "R4", 0);   // push indirect through reg 30
    run_op(8'h51, 8'h31, "R4", 0);   // pop indirect through reg 31
    run_op(8'h70, 8'h41, "R5", 0);   // low byte pushed first
    run_op(8'h70, 8'h40, "R5", 0);   // high byte on top
    run_op(8'hAF, 8'h00, "R5", 0);   // SP FD -> FF
    run_op(8'hAF, 8'h00, "R6", 0);   // SP FF reads FF then 00, ends 01
    run_op(8'h50, 8'h22, "R8", 1);   // second start during pop is ignored

    begin
      int we0;
      logic [7:0] sp0;
      we0 = nwe; sp0 = sp_o;
      @(negedge clk);
      start_i = 1'b1; opcode_i = 8'hFF; operand_i = 8'h10;
      @(negedge clk);
      start_i = 1'b0;
      repeat (8) @(negedge clk);
      check("R8", "sp after unknown opcode", {24'd0, sp_o}, {24'd0, sp0});
      check("R8", "writes after unknown opcode", nwe - we0, 0);
    end
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule